// File: doc/BRIEF.md
# Single-Channel Compare and PWM Timer

This block is an up-counting timer with one output-compare channel. The counter steps from zero to a period limit and then returns to zero. That wrap is the update event. A second value, the compare threshold, is checked against the counter. From that check the channel builds a reference level, which can be frozen, toggled on each match, or driven as a pulse-width-modulated wave in either sense. The reference then passes through a polarity inverter and an output gate before it reaches the pin.

Both the period limit and the compare threshold are held twice. Software writes a staging copy, and the counter and comparator use a working copy. A per-register staging enable decides when a write reaches the working copy: at once, or only at the next update event. Software can force an update event, which restarts the count and loads both working copies. An external clear input drives the reference inactive. The reference then stays inactive until the next period begins, so a fault can cut one pulse short without a glitch later in that period.

Software reaches the block through a write-only port with four word addresses. Address 0 is the control word. Its fields are: bit 0 run, bit 1 period staging enable, bit 2 threshold staging enable, bits 5:3 channel mode, bit 6 active-low output, bit 7 output enable and bit 8 match interrupt enable. Address 1 holds the period limit and address 2 the compare threshold. Address 3 takes event strobes: bit 0 forces an update and bit 1 clears the match flag.

Top module: `pwm_timer_chan`

## Requirements
- R1: While running, the counter goes up by one each clock. When the counter is greater than or equal to the working period limit, the next value is 0. `update_o` is high in exactly the cycles where a wrap is about to happen or an update is being forced.
- R2: With the period staging enable (control bit 1) clear, a write to address 1 reaches the working period limit on the same clock edge. With that bit set, the new limit takes effect only at the next update event, and the current period finishes with the old limit.
- R3: With the threshold staging enable (control bit 2) clear, a write to address 2 reaches the working threshold on the same edge. With that bit set, the new value takes effect only at the next update event.
- R4: Writing 1 to bit 0 of address 3 clears the counter to 0 on that edge, whether or not the counter is running. It also loads both staged values into their working copies.
- R5: In mode 110 the reference is active (1) when the counter value of the previous cycle was below the threshold, and inactive otherwise. Mode 111 gives the inverse level. The reference follows the counter with one clock of delay.
- R6: In mode 110, a threshold above the period limit keeps the reference active all the time, and a threshold of 0 keeps it inactive all the time.
- R7: In the two PWM modes, the reference is re-evaluated in only three cases: when the below-threshold result changes, on the first cycle after the mode leaves 000, and on the first cycle of each new period.
- R8: While the channel is in a PWM mode, a high `ext_clr` makes the reference inactive on the next edge. The reference stays inactive until the next period begins, even if the compare result changes in the meantime.
- R9: In mode 011 the reference inverts once each time the running counter equals the working threshold.
- R10: In mode 000 the reference keeps its value, whatever the counter does.
- R11: A match (the counter is running and equals the working threshold) sets the match flag. The flag stays set until software writes 1 to bit 1 of address 3. `irq_o` is the flag gated by control bit 8.
- R12: `pin_o` is 0 when control bit 7 is clear. Otherwise it equals the reference, inverted when control bit 6 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register word address |
| wr_data | input | 16 | Register write data |
| ext_clr | input | 1 | External reference clear |
| cnt_o | output | 16 | Current counter value |
| ref_o | output | 1 | Channel reference level |
| pin_o | output | 1 | Gated, polarity-adjusted output |
| update_o | output | 1 | Update event in this cycle |
| match_flag_o | output | 1 | Sticky compare match flag |
| irq_o | output | 1 | Match interrupt request |

## Verification
The embedded properties check every cycle that the counter steps by one or wraps, that a forced update returns it to zero, and that staged working values stay put between update events. They also check that a clear drives the reference low on the next edge, that frozen mode holds the reference, and that a match sets the flag. The bench scenarios are needed for behaviour that spans whole periods. That includes the duty cycle for each mode and threshold, whether a staged write lands in this period or the next, and a held clear being released at the start of the next period. It also includes toggle alternation across periods and the effect of polarity and enable on the pin.

// File: rtl/ptc_pkg.sv
package ptc_pkg;

  // Channel mode codes
  localparam logic [2:0] MODE_FROZEN = 3'b000;
  localparam logic [2:0] MODE_TOGGLE = 3'b011;
  localparam logic [2:0] MODE_PWM_LO = 3'b110;  // active below threshold
  localparam logic [2:0] MODE_PWM_HI = 3'b111;  // active at or above threshold

  // Register word addresses
  localparam logic [1:0] ADR_CTRL = 2'd0;
  localparam logic [1:0] ADR_PER  = 2'd1;
  localparam logic [1:0] ADR_THR  = 2'd2;
  localparam logic [1:0] ADR_EVT  = 2'd3;

  // Event strobe bits at ADR_EVT
  localparam int EVT_FORCE_UPD = 0;
  localparam int EVT_FLAG_CLR  = 1;

  // Control word, LSB first: run, per_stage, thr_stage, mode, act_low, out_en, irq_en
  typedef struct packed {
    logic       irq_en;
    logic       out_en;
    logic       act_low;
    logic [2:0] mode;
    logic       thr_stage;
    logic       per_stage;
    logic       run;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/ptc_regs.sv
module ptc_regs
  import ptc_pkg::*;
#(
  parameter int              CNT_W   = 16,
  parameter logic [CNT_W-1:0] PER_RST = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output ctrl_t            ctrl,
  output logic [CNT_W-1:0] per_stage_q,
  output logic [CNT_W-1:0] thr_stage_q,
  output logic             per_wr,
  output logic             thr_wr,
  output logic             force_upd,
  output logic             flag_clr
);

  logic evt_wr;

  assign per_wr    = wr_en && (wr_addr == ADR_PER);
  assign thr_wr    = wr_en && (wr_addr == ADR_THR);
  assign evt_wr    = wr_en && (wr_addr == ADR_EVT);
  assign force_upd = evt_wr && wr_data[EVT_FORCE_UPD];
  assign flag_clr  = evt_wr && wr_data[EVT_FLAG_CLR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl        <= '0;
      per_stage_q <= PER_RST;
      thr_stage_q <= '0;
    end else begin
      if (wr_en && (wr_addr == ADR_CTRL)) ctrl <= ctrl_t'(wr_data[CTRL_W-1:0]);
      if (per_wr) per_stage_q <= wr_data;
      if (thr_wr) thr_stage_q <= wr_data;
    end
  end

endmodule

// File: rtl/ptc_timebase.sv
module ptc_timebase #(
  parameter int              CNT_W   = 16,
  parameter logic [CNT_W-1:0] PER_RST = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             per_stage_en,
  input  logic [CNT_W-1:0] per_stage_q,
  input  logic             per_wr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             force_upd,
  output logic [CNT_W-1:0] cnt,
  output logic             uev
);

  logic [CNT_W-1:0] per_act;
  logic             wrap;

  // Next count value: back to zero at or past the limit
  function automatic logic [CNT_W-1:0] step_count(input logic [CNT_W-1:0] c,
                                                  input logic [CNT_W-1:0] lim);
    return (c >= lim) ? '0 : c + 1'b1;
  endfunction

  assign wrap = run && (cnt >= per_act);
  assign uev  = wrap || force_upd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (force_upd) cnt <= '0;
    else if (run)       cnt <= step_count(cnt, per_act);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      per_act <= PER_RST;
    else if (per_wr && !per_stage_en) per_act <= wr_data;
    else if (uev)                     per_act <= per_stage_q;
  end

  assert_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !force_upd && cnt >= per_act) |=> (cnt == '0));

  assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !force_upd && cnt < per_act) |=> (cnt == $past(cnt) + 1'b1));

  assert_force_R4: assert property (@(posedge clk) disable iff (!rst_n)
    force_upd |=> (cnt == '0));

  assert_per_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (per_stage_en && !uev) |=> $stable(per_act));

endmodule

// File: rtl/ptc_channel.sv
module ptc_channel
  import ptc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic             run,
  input  logic             uev,
  input  logic [2:0]       mode,
  input  logic             thr_stage_en,
  input  logic [CNT_W-1:0] thr_stage_q,
  input  logic             thr_wr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             ext_clr,
  input  logic             flag_clr,
  output logic             ref_q,
  output logic             flag_q
);

  logic [CNT_W-1:0] thr_act;
  logic [2:0]       mode_q;
  logic             below, below_q, below_chg;
  logic             is_pwm, enter_pwm, period_start, clr_hold;
  logic             match_evt, pwm_lvl;

  function automatic logic cnt_below(input logic [CNT_W-1:0] c, input logic [CNT_W-1:0] t);
    return c < t;
  endfunction

  function automatic logic pwm_level(input logic [2:0] m, input logic b);
    return (m == MODE_PWM_HI) ? !b : b;
  endfunction

  assign below        = cnt_below(cnt, thr_act);
  assign below_chg    = below != below_q;
  assign is_pwm       = (mode == MODE_PWM_LO) || (mode == MODE_PWM_HI);
  assign enter_pwm    = is_pwm && (mode_q == MODE_FROZEN);
  assign match_evt    = run && (cnt == thr_act);
  assign pwm_lvl      = pwm_level(mode, below);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      thr_act <= '0;
    else if (thr_wr && !thr_stage_en) thr_act <= wr_data;
    else if (uev)                     thr_act <= thr_stage_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q       <= MODE_FROZEN;
      below_q      <= 1'b0;
      period_start <= 1'b0;
      clr_hold     <= 1'b0;
    end else begin
      mode_q       <= mode;
      below_q      <= below;
      period_start <= uev;
      if (ext_clr && is_pwm) clr_hold <= 1'b1;
      else if (uev)          clr_hold <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_q <= 1'b0;
    else if (is_pwm) begin
      if (ext_clr || clr_hold) ref_q <= 1'b0;
      else if (below_chg || enter_pwm || period_start) ref_q <= pwm_lvl;
    end else if (mode == MODE_TOGGLE && match_evt) ref_q <= !ref_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         flag_q <= 1'b0;
    else if (match_evt) flag_q <= 1'b1;
    else if (flag_clr)  flag_q <= 1'b0;
  end

  assert_thr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_stage_en && !uev) |=> $stable(thr_act));

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_clr && is_pwm) |=> !ref_q);

  assert_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_FROZEN) |=> $stable(ref_q));

  assert_flag_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> flag_q);

endmodule

// File: rtl/pwm_timer_chan.sv
module pwm_timer_chan
  import ptc_pkg::*;
#(
  parameter int              CNT_W   = 16,
  parameter logic [CNT_W-1:0] PER_RST = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             ext_clr,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ref_o,
  output logic             pin_o,
  output logic             update_o,
  output logic             match_flag_o,
  output logic             irq_o
);

  ctrl_t            ctrl;
  logic [CNT_W-1:0] per_stage_q, thr_stage_q;
  logic             per_wr, thr_wr, force_upd, flag_clr, uev;

  ptc_regs #(.CNT_W(CNT_W), .PER_RST(PER_RST)) regs_i (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data,
    .ctrl, .per_stage_q, .thr_stage_q, .per_wr, .thr_wr, .force_upd, .flag_clr
  );

  ptc_timebase #(.CNT_W(CNT_W), .PER_RST(PER_RST)) tb_i (
    .clk, .rst_n, .run(ctrl.run), .per_stage_en(ctrl.per_stage),
    .per_stage_q, .per_wr, .wr_data, .force_upd, .cnt(cnt_o), .uev
  );

  ptc_channel #(.CNT_W(CNT_W)) ch_i (
    .clk, .rst_n, .cnt(cnt_o), .run(ctrl.run), .uev, .mode(ctrl.mode),
    .thr_stage_en(ctrl.thr_stage), .thr_stage_q, .thr_wr, .wr_data,
    .ext_clr, .flag_clr, .ref_q(ref_o), .flag_q(match_flag_o)
  );

  assign update_o = uev;
  assign pin_o    = ctrl.out_en && (ref_o ^ ctrl.act_low);
  assign irq_o    = match_flag_o && ctrl.irq_en;

endmodule

// File: tb/pwm_timer_chan_tb.sv
module pwm_timer_chan_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        ext_clr = 1'b0;
  logic [15:0] cnt;
  logic        ref_o, pin_o, update_o, flag_o, irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  pwm_timer_chan dut_i (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .ext_clr,
    .cnt_o(cnt), .ref_o, .pin_o, .update_o, .match_flag_o(flag_o), .irq_o
  );

  // {period, threshold, inverted-sense}
  localparam logic [32:0] VECS [8] = '{
    {16'd9,  16'd3,  1'b0}, {16'd9,  16'd3,  1'b1},
    {16'd7,  16'd0,  1'b0}, {16'd7,  16'd0,  1'b1},
    {16'd5,  16'd9,  1'b0}, {16'd5,  16'd6,  1'b0},
    {16'd12, 16'd12, 1'b1}, {16'd3,  16'd1,  1'b0}
  };

  function automatic logic [15:0] ctl(bit run, bit pst, bit tst, logic [2:0] m,
                                      bit lo, bit oe, bit ie);
    return {7'd0, ie, oe, lo, m, tst, pst, run};
  endfunction

  function automatic bit want_ref(bit inv, int prev, int thr);
    return inv ? (prev >= thr) : (thr > prev);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_cnt(int v);
    do @(negedge clk); while (cnt != 16'(v));
  endtask

  task automatic pulse_clr();
    ext_clr = 1'b1; @(negedge clk); ext_clr = 1'b0;
  endtask

  task automatic max_cnt(int n, output int mx);
    mx = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (int'(cnt) > mx) mx = int'(cnt);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int mx, a, bad, prev, per, thr;
    bit inv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset state
    chk("R1 reset cnt", cnt, 0);
    chk("R12 reset pin", pin_o, 0);
    chk("R11 reset flag/irq", {flag_o, irq_o, ref_o, update_o}, 0);

    // Vector table: PWM levels over full periods
    for (int i = 0; i < 8; i++) begin
      {per, thr, inv} = {VECS[i][32:17], VECS[i][16:1], VECS[i][0]};
      per = int'(VECS[i][32:17]); thr = int'(VECS[i][16:1]); inv = VECS[i][0];
      wr(2'd0, ctl(0, 0, 0, 3'b000, 0, 1, 0));
      wr(2'd1, 16'(per));
      wr(2'd2, 16'(thr));
      wr(2'd0, ctl(1, 0, 0, inv ? 3'b111 : 3'b110, 0, 1, 0));
      wr(2'd3, 16'h1);
      @(negedge clk); @(negedge clk);
      prev = int'(cnt); bad = 0;
      for (int n = 0; n < 2 * (per + 1) + 4; n++) begin
        @(negedge clk);
        if (int'(cnt) != ((prev >= per) ? 0 : prev + 1)) bad++;           // R1
        if (ref_o != want_ref(inv, prev, thr)) bad++;                       // R5
        if (update_o != (int'(cnt) >= per)) bad++;                          // R1
        prev = int'(cnt);
      end
      chk((thr == 0 || thr > per) ? "R6 vector" : "R5 R1 vector", bad, 0);
    end

    // R3 threshold staging
    wr(2'd1, 16'd9);
    wr(2'd2, 16'd7);
    wr(2'd0, ctl(1, 0, 0, 3'b110, 0, 1, 0));
    wait_cnt(0); wr(2'd2, 16'd3);
    wait_cnt(6); chk("R3 immediate threshold", ref_o, 0);
    wr(2'd0, ctl(1, 0, 1, 3'b110, 0, 1, 0));
    wait_cnt(0); wr(2'd2, 16'd7);
    wait_cnt(6); chk("R3 staged held this period", ref_o, 0);
    wait_cnt(0); wait_cnt(6); chk("R3 staged applied next period", ref_o, 1);

    // R8 clear in low-sense PWM
    wr(2'd0, ctl(1, 0, 0, 3'b110, 0, 1, 0));
    wr(2'd2, 16'd6);
    wait_cnt(0); wait_cnt(2); pulse_clr();
    chk("R8 clear immediate", ref_o, 0);
    wait_cnt(5); chk("R8 clear held", ref_o, 0);
    wait_cnt(2); chk("R8 released next period", ref_o, 1);

    // R8 hold blocks compare change in inverted sense
    wr(2'd2, 16'd3);
    wr(2'd0, ctl(1, 0, 0, 3'b111, 0, 1, 0));
    wait_cnt(0); wait_cnt(0);
    wait_cnt(1); pulse_clr();
    wait_cnt(6); chk("R8 hold over compare change", ref_o, 0);
    wait_cnt(6); chk("R8 inverted next period", ref_o, 1);

    // R6/R7 threshold above period, clear then period-start recovery
    wr(2'd2, 16'd20);
    wr(2'd0, ctl(1, 0, 0, 3'b110, 0, 1, 0));
    wait_cnt(0); wait_cnt(0);
    wait_cnt(2); chk("R6 always active", ref_o, 1);
    pulse_clr();
    wait_cnt(5); chk("R8 cleared above-period", ref_o, 0);
    wait_cnt(2); chk("R7 period start re-evaluation", ref_o, 1);

    // R9 toggle, R11 flag and irq
    wr(2'd2, 16'd4);
    wr(2'd0, ctl(1, 0, 0, 3'b011, 0, 1, 1));
    wait_cnt(6); wr(2'd3, 16'h2);
    wait_cnt(9);
    chk("R11 flag cleared", flag_o, 0);
    chk("R11 irq cleared", irq_o, 0);
    a = ref_o;
    wait_cnt(6);
    chk("R11 flag set on match", flag_o, 1);
    chk("R11 irq raised", irq_o, 1);
    chk("R9 toggled", ref_o, !a);
    wait_cnt(9); wait_cnt(6);
    chk("R9 toggled back", ref_o, a);

    // R10 frozen
    wr(2'd0, ctl(1, 0, 0, 3'b000, 0, 1, 0));
    a = ref_o; bad = 0;
    for (int n = 0; n < 25; n++) begin
      @(negedge clk);
      if (ref_o != a) bad++;
    end
    chk("R10 frozen hold", bad, 0);

    // R12 polarity and enable
    wr(2'd2, 16'd5);
    wr(2'd0, ctl(1, 0, 0, 3'b110, 0, 0, 0));
    bad = 0;
    for (int n = 0; n < 12; n++) begin @(negedge clk); if (pin_o) bad++; end
    chk("R12 gated off", bad, 0);
    wr(2'd0, ctl(1, 0, 0, 3'b110, 1, 1, 0));
    bad = 0;
    for (int n = 0; n < 12; n++) begin @(negedge clk); if (pin_o != !ref_o) bad++; end
    chk("R12 active low", bad, 0);
    wr(2'd0, ctl(1, 0, 0, 3'b110, 0, 1, 0));
    bad = 0;
    for (int n = 0; n < 12; n++) begin @(negedge clk); if (pin_o != ref_o) bad++; end
    chk("R12 active high", bad, 0);

    // R2 period staging
    wr(2'd0, ctl(1, 1, 0, 3'b110, 0, 1, 0));
    wait_cnt(1); wr(2'd1, 16'd4);
    max_cnt(8, mx); chk("R2 staged period kept", mx, 9);
    max_cnt(12, mx); chk("R2 staged period applied", mx, 4);
    wr(2'd0, ctl(1, 0, 0, 3'b110, 0, 1, 0));
    wait_cnt(1); wr(2'd1, 16'd2);
    @(negedge clk); @(negedge clk);
    max_cnt(10, mx); chk("R2 immediate period", mx, 2);

    // R4 forced update
    wr(2'd0, ctl(0, 1, 0, 3'b110, 0, 1, 0));
    wr(2'd1, 16'd6);
    wr(2'd3, 16'h1);
    chk("R4 forced clear", cnt, 0);
    wr(2'd0, ctl(1, 1, 0, 3'b110, 0, 1, 0));
    max_cnt(20, mx); chk("R4 forced load", mx, 6);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule